// File: doc/BRIEF.md
# UART Receiver with Error Classification

This block receives an asynchronous serial line that is sampled sixteen times per bit period, rebuilds each character, and sorts every reception into one of several outcomes. These are a plain character, a parity fault, a missing stop bit, a run of idle characters long enough to end a message, and a line break. Results leave through a two-entry record queue. Each record carries the character, a close indication that ends the current receive buffer, and a five-bit status code. Downstream logic reads the head record and pops it.

Idle characters (all ones) are counted rather than stored. When the count of consecutive idle characters reaches a programmable limit and a buffer is open, the receive buffer is closed. A break is a character that is all zero and has a missing stop bit. Its length is measured in bit times and a running break counter is kept. Two interrupt request outputs pulse for one cycle, each qualified by its own enable input.

Top module: `uart_rx_classifier`

## Requirements
- R1: One character is a low start bit, DATA_BITS data bits sent LSB first, an optional parity bit and a stop bit, each bit lasting 16 sample ticks. The start bit is confirmed at its middle, and a start whose middle vote is high is discarded and leaves no record.
- R2: Each bit value is the majority of its 7th, 8th and 9th samples, so a single wrong sample among them does not change the received bit.
- R3: With parity_en high, the parity bit must make the number of ones in data plus parity even (parity_odd low) or odd (parity_odd high). A mismatch stores the character with close set and status bit 3 set.
- R4: A low stop bit on a character that is not a break stores the character with close set and only status bit 2 set, and parity is not checked for it.
- R5: Records wait in a two-entry queue, and the head stays on out_data until out_pop. A record arriving while the queue is full and not popped is dropped, and the newest stored record gets close and status bit 4. The status encoding is bit 4 overrun, bit 3 parity, bit 2 framing, bit 1 break, bit 0 idle close.
- R6: A character with a valid stop bit whose data bits are all ones (and whose parity bit is one when parity is enabled) is not stored. It adds one to a consecutive-idle count that stops at max_idle. The step that brings the count to a nonzero max_idle while buf_open is high pushes a record with data 0, close set and status bit 0.
- R7: When buf_open is low at the moment the idle count reaches max_idle, no record is pushed and no interrupt is raised.
- R8: Any received character that is not idle, and any break, clears the idle count.
- R9: A character whose data (and parity bit, if enabled) are zero with a low stop bit starts a break. Its length is the number of bit times from the start bit up to the first bit whose middle vote is high, limited to BRK_LEN_MAX. When the line returns high, brk_len takes that length and brk_count increases by one.
- R10: A break ending while buf_open is high pushes a record with data 0, close set and status bit 1, and a break ending with buf_open low pushes nothing.
- R11: rx_irq pulses for one cycle for each pushed record with close set and for each overrun, but only while rx_irq_en is high. brk_irq pulses for one cycle per break, but only while brk_irq_en is high.
- R12: After reset the queue is empty, brk_count and brk_len are zero and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_tick | input | 1 | Sample strobe at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| parity_en | input | 1 | A parity bit follows the data bits |
| parity_odd | input | 1 | Odd parity when high, even when low |
| max_idle | input | IDLE_W | Consecutive idle characters that close a buffer, 0 disables |
| buf_open | input | 1 | Downstream has a receive buffer open |
| rx_irq_en | input | 1 | Enable for rx_irq |
| brk_irq_en | input | 1 | Enable for brk_irq |
| out_pop | input | 1 | Remove the head record |
| out_valid | output | 1 | A record is present at the head |
| out_data | output | DATA_BITS | Head record character |
| out_close | output | 1 | Head record closes the buffer |
| out_status | output | 5 | Head record status code |
| rx_irq | output | 1 | Receive interrupt pulse |
| brk_irq | output | 1 | Break interrupt pulse |
| brk_count | output | BRK_CNT_W | Number of breaks seen, wrapping |
| brk_len | output | LEN_W | Length of the last break in bit times |

## Verification
The bench builds the block with its defaults: 8 data bits, a 4-bit idle limit driven to 3, and break lengths limited to 16 bit times. With these values a single 20-bit break reaches the length limit, and five idle characters show both the closing step and the hold that follows it. Three characters sent without popping fill the two-entry queue and then overrun it. Parity is switched on and off at run time, so even, odd and disabled framing all fall within one run.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OVS      = 16;
    localparam int VOTE_IDX = 8;
    localparam int FLAG_W   = 5;

    typedef struct packed {
        logic ov;
        logic pr;
        logic fr;
        logic br;
        logic idl;
    } rx_flags_t;

    typedef enum logic [1:0] {
        SMP_IDLE  = 2'd0,
        SMP_FRAME = 2'd1,
        SMP_BREAK = 2'd2
    } smp_state_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int BRK_LEN_MAX = 16,
    parameter int LEN_W       = $clog2(BRK_LEN_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 samp_tick,
    input  logic                 rxd,
    input  logic                 parity_en,
    output logic                 frm_vld,
    output logic [DATA_BITS-1:0] frm_data,
    output logic                 frm_par,
    output logic                 frm_stop,
    output logic                 brk_vld,
    output logic [LEN_W-1:0]     brk_len
);

    localparam int IDX_W = $clog2(OVS);
    localparam int POS_W = $clog2(DATA_BITS + 4);

    smp_state_t           st;
    logic [IDX_W-1:0]     idx;
    logic [IDX_W-1:0]     nidx;
    logic [POS_W-1:0]     pos;
    logic [POS_W-1:0]     stop_pos;
    logic [1:0]           hist;
    logic [DATA_BITS-1:0] dat;
    logic                 par_q;
    logic [LEN_W-1:0]     len_q;
    logic [LEN_W-1:0]     len_init;
    logic                 vote;
    logic                 at_vote;
    logic                 all_zero;
    int                   frame_bits;

    always_comb begin
        nidx       = idx + 1'b1;
        at_vote    = samp_tick && (nidx == IDX_W'(VOTE_IDX));
        vote       = maj3(hist[1], hist[0], rxd);
        stop_pos   = parity_en ? POS_W'(DATA_BITS + 2) : POS_W'(DATA_BITS + 1);
        all_zero   = (dat == '0) && (!parity_en || !par_q);
        frame_bits = int'(stop_pos) + 1;
        len_init   = (frame_bits > BRK_LEN_MAX) ? LEN_W'(BRK_LEN_MAX) : LEN_W'(frame_bits);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SMP_IDLE;
            idx      <= '0;
            pos      <= '0;
            hist     <= 2'b11;
            dat      <= '0;
            par_q    <= 1'b0;
            len_q    <= '0;
            frm_vld  <= 1'b0;
            frm_data <= '0;
            frm_par  <= 1'b0;
            frm_stop <= 1'b0;
            brk_vld  <= 1'b0;
            brk_len  <= '0;
        end else begin
            frm_vld <= 1'b0;
            brk_vld <= 1'b0;
            if (samp_tick) begin
                hist <= {hist[0], rxd};
                unique case (st)
                    SMP_IDLE: begin
                        if (!rxd) begin
                            st  <= SMP_FRAME;
                            idx <= '0;
                            pos <= '0;
                        end
                    end
                    SMP_FRAME: begin
                        idx <= nidx;
                        if (at_vote) begin
                            if (pos == '0) begin
                                if (vote) st <= SMP_IDLE;
                                else      pos <= pos + 1'b1;
                            end else if (pos == stop_pos) begin
                                if (vote || !all_zero) begin
                                    frm_vld  <= 1'b1;
                                    frm_data <= dat;
                                    frm_par  <= par_q;
                                    frm_stop <= vote;
                                    st       <= SMP_IDLE;
                                end else begin
                                    len_q <= len_init;
                                    st    <= SMP_BREAK;
                                end
                            end else if (pos <= POS_W'(DATA_BITS)) begin
                                dat <= {vote, dat[DATA_BITS-1:1]};
                                pos <= pos + 1'b1;
                            end else begin
                                par_q <= vote;
                                pos   <= pos + 1'b1;
                            end
                        end
                    end
                    SMP_BREAK: begin
                        idx <= nidx;
                        if (at_vote) begin
                            if (vote) begin
                                brk_vld <= 1'b1;
                                brk_len <= len_q;
                                st      <= SMP_IDLE;
                            end else if (len_q != LEN_W'(BRK_LEN_MAX)) begin
                                len_q <= len_q + 1'b1;
                            end
                        end
                    end
                    default: st <= SMP_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_rx_classify.sv
module uart_rx_classify
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int IDLE_W    = 4,
    parameter int BRK_CNT_W = 8,
    parameter int LEN_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frm_vld,
    input  logic [DATA_BITS-1:0] frm_data,
    input  logic                 frm_par,
    input  logic                 frm_stop,
    input  logic                 brk_vld,
    input  logic [LEN_W-1:0]     brk_len_in,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    input  logic [IDLE_W-1:0]    max_idle,
    input  logic                 buf_open,
    input  logic                 rx_irq_en,
    input  logic                 brk_irq_en,
    input  logic                 fifo_ovr,
    output logic                 push,
    output logic [DATA_BITS-1:0] push_data,
    output logic                 push_close,
    output rx_flags_t            push_flags,
    output logic                 rx_irq,
    output logic                 brk_irq,
    output logic [BRK_CNT_W-1:0] brk_count,
    output logic [LEN_W-1:0]     brk_len
);

    logic [IDLE_W-1:0] idle_cnt;
    logic [IDLE_W-1:0] idle_next;
    logic              is_idle;
    logic              idle_hit;
    logic              par_bad;

    always_comb begin
        is_idle   = frm_stop && (&frm_data) && (!parity_en || frm_par);
        par_bad   = parity_en && (frm_par != ((^frm_data) ^ parity_odd));
        idle_next = idle_cnt + 1'b1;
        idle_hit  = (idle_cnt < max_idle) && (idle_next == max_idle);
    end

    always_comb begin
        push       = 1'b0;
        push_data  = '0;
        push_close = 1'b0;
        push_flags = '0;
        if (brk_vld) begin
            push          = buf_open;
            push_close    = 1'b1;
            push_flags.br = 1'b1;
        end else if (frm_vld) begin
            if (!frm_stop) begin
                push          = 1'b1;
                push_data     = frm_data;
                push_close    = 1'b1;
                push_flags.fr = 1'b1;
            end else if (is_idle) begin
                if (idle_hit && buf_open) begin
                    push           = 1'b1;
                    push_close     = 1'b1;
                    push_flags.idl = 1'b1;
                end
            end else if (par_bad) begin
                push          = 1'b1;
                push_data     = frm_data;
                push_close    = 1'b1;
                push_flags.pr = 1'b1;
            end else begin
                push      = 1'b1;
                push_data = frm_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_cnt  <= '0;
            rx_irq    <= 1'b0;
            brk_irq   <= 1'b0;
            brk_count <= '0;
            brk_len   <= '0;
        end else begin
            rx_irq  <= rx_irq_en && ((push && push_close) || fifo_ovr);
            brk_irq <= brk_irq_en && brk_vld;
            if (brk_vld) begin
                idle_cnt  <= '0;
                brk_count <= brk_count + 1'b1;
                brk_len   <= brk_len_in;
            end else if (frm_vld) begin
                if (is_idle) begin
                    if (idle_cnt < max_idle) idle_cnt <= idle_next;
                end else begin
                    idle_cnt <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int           W         = 14,
    parameter int           DEPTH     = 2,
    parameter logic [W-1:0] MARK_MASK = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic         valid,
    output logic [W-1:0] rdata,
    output logic         ovr
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic [PW-1:0] tail;
    logic [CW-1:0] cnt;
    logic          full;
    logic          wr_fire;
    logic          rd_fire;

    always_comb begin
        full    = (cnt == CW'(DEPTH));
        valid   = (cnt != '0);
        rd_fire = rd && valid;
        wr_fire = wr && (!full || rd);
        ovr     = wr && full && !rd;
        tail    = (wp == '0) ? PW'(DEPTH - 1) : wp - 1'b1;
        rdata   = mem[rp];
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (wr_fire && (wp == PW'(i))) begin
                mem[i] <= wdata;
            end else if (ovr && (tail == PW'(i))) begin
                mem[i] <= mem[i] | MARK_MASK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_fire) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (rd_fire) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (wr_fire && !rd_fire)      cnt <= cnt + 1'b1;
            else if (rd_fire && !wr_fire) cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/uart_rx_classifier.sv
module uart_rx_classifier
    import uart_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int IDLE_W      = 4,
    parameter int BRK_CNT_W   = 8,
    parameter int BRK_LEN_MAX = 16,
    parameter int FIFO_DEPTH  = 2,
    parameter int LEN_W       = $clog2(BRK_LEN_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 samp_tick,
    input  logic                 rxd,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    input  logic [IDLE_W-1:0]    max_idle,
    input  logic                 buf_open,
    input  logic                 rx_irq_en,
    input  logic                 brk_irq_en,
    input  logic                 out_pop,
    output logic                 out_valid,
    output logic [DATA_BITS-1:0] out_data,
    output logic                 out_close,
    output logic [4:0]           out_status,
    output logic                 rx_irq,
    output logic                 brk_irq,
    output logic [BRK_CNT_W-1:0] brk_count,
    output logic [LEN_W-1:0]     brk_len
);

    localparam int REC_W = DATA_BITS + 1 + FLAG_W;
    localparam logic [REC_W-1:0] MARK = REC_W'(6'b11_0000);

    logic                 frm_vld;
    logic [DATA_BITS-1:0] frm_data;
    logic                 frm_par;
    logic                 frm_stop;
    logic                 brk_vld;
    logic [LEN_W-1:0]     brk_len_raw;
    logic                 push;
    logic [DATA_BITS-1:0] push_data;
    logic                 push_close;
    rx_flags_t            push_flags;
    logic                 fifo_ovr;
    logic [REC_W-1:0]     head;

    uart_rx_sampler #(
        .DATA_BITS  (DATA_BITS),
        .BRK_LEN_MAX(BRK_LEN_MAX),
        .LEN_W      (LEN_W)
    ) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .samp_tick(samp_tick),
        .rxd      (rxd),
        .parity_en(parity_en),
        .frm_vld  (frm_vld),
        .frm_data (frm_data),
        .frm_par  (frm_par),
        .frm_stop (frm_stop),
        .brk_vld  (brk_vld),
        .brk_len  (brk_len_raw)
    );

    uart_rx_classify #(
        .DATA_BITS(DATA_BITS),
        .IDLE_W   (IDLE_W),
        .BRK_CNT_W(BRK_CNT_W),
        .LEN_W    (LEN_W)
    ) u_classify (
        .clk       (clk),
        .rst       (rst),
        .frm_vld   (frm_vld),
        .frm_data  (frm_data),
        .frm_par   (frm_par),
        .frm_stop  (frm_stop),
        .brk_vld   (brk_vld),
        .brk_len_in(brk_len_raw),
        .parity_en (parity_en),
        .parity_odd(parity_odd),
        .max_idle  (max_idle),
        .buf_open  (buf_open),
        .rx_irq_en (rx_irq_en),
        .brk_irq_en(brk_irq_en),
        .fifo_ovr  (fifo_ovr),
        .push      (push),
        .push_data (push_data),
        .push_close(push_close),
        .push_flags(push_flags),
        .rx_irq    (rx_irq),
        .brk_irq   (brk_irq),
        .brk_count (brk_count),
        .brk_len   (brk_len)
    );

    uart_rx_fifo #(
        .W        (REC_W),
        .DEPTH    (FIFO_DEPTH),
        .MARK_MASK(MARK)
    ) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .wr   (push),
        .wdata({push_data, push_close, push_flags}),
        .rd   (out_pop),
        .valid(out_valid),
        .rdata(head),
        .ovr  (fifo_ovr)
    );

    assign out_data   = head[REC_W-1 -: DATA_BITS];
    assign out_close  = head[FLAG_W];
    assign out_status = head[FLAG_W-1:0];

endmodule

// File: rtl/uart_rx_classifier_chk.sv
module uart_rx_classifier_chk #(
    parameter int DATA_BITS   = 8,
    parameter int BRK_CNT_W   = 8,
    parameter int BRK_LEN_MAX = 16,
    parameter int LEN_W       = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 out_pop,
    input logic                 out_valid,
    input logic [DATA_BITS-1:0] out_data,
    input logic                 out_close,
    input logic [4:0]           out_status,
    input logic                 brk_irq,
    input logic [BRK_CNT_W-1:0] brk_count,
    input logic [LEN_W-1:0]     brk_len
);

    // R9
    brk_len_cap_chk: assert property (@(posedge clk) disable iff (rst)
        brk_len <= LEN_W'(BRK_LEN_MAX));

    // R9
    brk_count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_count != $past(brk_count)) |-> (brk_count == $past(brk_count) + 1'b1));

    // R11
    brk_irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        brk_irq |=> !brk_irq);

    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_pop) |=> (out_valid && $stable(out_data)));

    // R4
    status_close_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_status != 5'b0)) |-> out_close);

endmodule

bind uart_rx_classifier uart_rx_classifier_chk #(
    .DATA_BITS  (DATA_BITS),
    .BRK_CNT_W  (BRK_CNT_W),
    .BRK_LEN_MAX(BRK_LEN_MAX),
    .LEN_W      (LEN_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_pop   (out_pop),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_close (out_close),
    .out_status(out_status),
    .brk_irq   (brk_irq),
    .brk_count (brk_count),
    .brk_len   (brk_len)
);

// File: tb/uart_rx_classifier_bench.sv
module uart_rx_classifier_bench;

    localparam int DB  = 8;
    localparam int IW  = 4;
    localparam int BCW = 8;
    localparam int BLM = 16;
    localparam int LW  = 5;

    localparam logic [4:0] S_OV  = 5'b10000;
    localparam logic [4:0] S_PR  = 5'b01000;
    localparam logic [4:0] S_FR  = 5'b00100;
    localparam logic [4:0] S_BR  = 5'b00010;
    localparam logic [4:0] S_IDL = 5'b00001;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          samp_tick = 1'b1;
    logic          rxd = 1'b1;
    logic          parity_en = 1'b0;
    logic          parity_odd = 1'b0;
    logic [IW-1:0] max_idle = 4'd3;
    logic          buf_open = 1'b1;
    logic          rx_irq_en = 1'b1;
    logic          brk_irq_en = 1'b1;
    logic          out_pop = 1'b0;
    logic          out_valid;
    logic [DB-1:0] out_data;
    logic          out_close;
    logic [4:0]    out_status;
    logic          rx_irq;
    logic          brk_irq;
    logic [BCW-1:0] brk_count;
    logic [LW-1:0] brk_len;

    always #10 clk = ~clk;

    uart_rx_classifier #(
        .DATA_BITS(DB), .IDLE_W(IW), .BRK_CNT_W(BCW), .BRK_LEN_MAX(BLM), .FIFO_DEPTH(2), .LEN_W(LW)
    ) u_uart_rx_classifier (
        .clk(clk), .rst(rst), .samp_tick(samp_tick), .rxd(rxd),
        .parity_en(parity_en), .parity_odd(parity_odd), .max_idle(max_idle),
        .buf_open(buf_open), .rx_irq_en(rx_irq_en), .brk_irq_en(brk_irq_en),
        .out_pop(out_pop), .out_valid(out_valid), .out_data(out_data),
        .out_close(out_close), .out_status(out_status), .rx_irq(rx_irq),
        .brk_irq(brk_irq), .brk_count(brk_count), .brk_len(brk_len)
    );

    typedef struct packed {
        logic [DB-1:0] d;
        logic          c;
        logic [4:0]    s;
    } rec_t;

    rec_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    int act_rx = 0;
    int act_brk = 0;
    int exp_rx = 0;
    int exp_brk = 0;
    int m_idle = 0;
    int m_brkcnt = 0;
    int m_brklen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_irq)  act_rx++;
            if (brk_irq) act_brk++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_push(input rec_t r);
        rec_t t;
        if (q.size() < 2) begin
            q.push_back(r);
            if (r.c && rx_irq_en) exp_rx++;
        end else begin
            t = q[1];
            t.c = 1'b1;
            t.s = t.s | S_OV;
            q[1] = t;
            if (rx_irq_en) exp_rx++;
        end
    endtask

    task automatic model_frame(input logic [DB-1:0] d, input logic pb, input logic stop);
        logic good_pb;
        good_pb = (^d) ^ parity_odd;
        if (!stop) begin
            model_push('{d: d, c: 1'b1, s: S_FR});
            m_idle = 0;
        end else if (d == 8'hFF && (!parity_en || pb)) begin
            if (m_idle < int'(max_idle)) begin
                m_idle++;
                if (m_idle == int'(max_idle) && buf_open)
                    model_push('{d: '0, c: 1'b1, s: S_IDL});
            end
        end else if (parity_en && pb != good_pb) begin
            model_push('{d: d, c: 1'b1, s: S_PR});
            m_idle = 0;
        end else begin
            model_push('{d: d, c: 1'b0, s: 5'b0});
            m_idle = 0;
        end
    endtask

    task automatic drive_bit(input logic v, input int glitch_at);
        for (int s = 1; s <= 16; s++) begin
            @(negedge clk);
            rxd = (s == glitch_at) ? ~v : v;
        end
    endtask

    task automatic send_frame(input logic [DB-1:0] d, input bit bad_par, input logic stop, input int glitch_bit);
        logic pb;
        pb = parity_en ? ((^d) ^ parity_odd ^ bad_par) : 1'b0;
        drive_bit(1'b0, -1);
        for (int b = 0; b < DB; b++) drive_bit(d[b], (b == glitch_bit) ? 8 : -1);
        if (parity_en) drive_bit(pb, -1);
        drive_bit(stop, -1);
        if (!stop) drive_bit(1'b1, -1);
        model_frame(d, pb, stop);
    endtask

    task automatic send_break(input int nbits);
        for (int b = 0; b < nbits; b++) drive_bit(1'b0, -1);
        drive_bit(1'b1, -1);
        drive_bit(1'b1, -1);
        m_idle = 0;
        m_brkcnt++;
        m_brklen = (nbits > BLM) ? BLM : nbits;
        if (brk_irq_en) exp_brk++;
        if (buf_open) model_push('{d: '0, c: 1'b1, s: S_BR});
    endtask

    task automatic drain(input string req);
        while (q.size() > 0) begin
            rec_t e;
            e = q.pop_front();
            @(negedge clk);
            chk(out_valid == 1'b1, req, "record present", int'(out_valid), 1);
            chk({out_data, out_close, out_status} == e, req, "record {data,close,status}",
                int'({out_data, out_close, out_status}), int'(e));
            out_pop = 1'b1;
            @(negedge clk);
            out_pop = 1'b0;
        end
        @(negedge clk);
        chk(out_valid == 1'b0, req, "queue empty after drain", int'(out_valid), 0);
    endtask

    task automatic chk_irqs(input string req);
        chk(act_rx == exp_rx, req, "rx_irq pulse count", act_rx, exp_rx);
        chk(act_brk == exp_brk, req, "brk_irq pulse count", act_brk, exp_brk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(out_valid == 1'b0, "R12", "out_valid after reset", int'(out_valid), 0);
        chk(brk_count == '0, "R12", "brk_count after reset", int'(brk_count), 0);
        chk(brk_len == '0, "R12", "brk_len after reset", int'(brk_len), 0);
        chk(!rx_irq && !brk_irq, "R12", "irq outputs after reset", int'({rx_irq, brk_irq}), 0);
        drive_bit(1'b1, -1);

        // R1 plain characters, LSB first, close 0 status 0
        send_frame(8'h55, 1'b0, 1'b1, -1);
        send_frame(8'hA3, 1'b0, 1'b1, -1);
        drain("R1");

        // R2 one wrong sample at the 8th position of data bit 3
        send_frame(8'h3C, 1'b0, 1'b1, 3);
        drain("R2");

        // R1 false start: short low pulse, then a valid character
        for (int s = 0; s < 4; s++) begin @(negedge clk); rxd = 1'b0; end
        for (int s = 0; s < 24; s++) begin @(negedge clk); rxd = 1'b1; end
        chk(out_valid == 1'b0, "R1", "no record after false start", int'(out_valid), 0);
        send_frame(8'h81, 1'b0, 1'b1, -1);
        drain("R1");

        // R3 even then odd parity, good and bad
        parity_en = 1'b1;
        send_frame(8'h5A, 1'b0, 1'b1, -1);
        send_frame(8'h5A, 1'b1, 1'b1, -1);
        drain("R3");
        parity_odd = 1'b1;
        send_frame(8'h07, 1'b0, 1'b1, -1);
        send_frame(8'h07, 1'b1, 1'b1, -1);
        drain("R3");
        parity_odd = 1'b0;

        // R4 framing error with bad parity: only the framing flag
        send_frame(8'h12, 1'b1, 1'b0, -1);
        drain("R4");
        parity_en = 1'b0;
        send_frame(8'hC4, 1'b0, 1'b0, -1);
        drain("R4");
        chk_irqs("R11");

        // R5 overrun: three characters, no pop
        send_frame(8'h11, 1'b0, 1'b1, -1);
        send_frame(8'h22, 1'b0, 1'b1, -1);
        send_frame(8'h33, 1'b0, 1'b1, -1);
        drain("R5");
        chk_irqs("R11");

        // R6 idle close after three, then the count holds
        send_frame(8'hFF, 1'b0, 1'b1, -1);
        send_frame(8'hFF, 1'b0, 1'b1, -1);
        send_frame(8'hFF, 1'b0, 1'b1, -1);
        drain("R6");
        send_frame(8'hFF, 1'b0, 1'b1, -1);
        send_frame(8'hFF, 1'b0, 1'b1, -1);
        drain("R6");

        // R8 a non-idle character restarts the count
        send_frame(8'h40, 1'b0, 1'b1, -1);
        send_frame(8'hFF, 1'b0, 1'b1, -1);
        send_frame(8'hFF, 1'b0, 1'b1, -1);
        send_frame(8'h41, 1'b0, 1'b1, -1);
        send_frame(8'hFF, 1'b0, 1'b1, -1);
        send_frame(8'hFF, 1'b0, 1'b1, -1);
        drain("R8");
        send_frame(8'hFF, 1'b0, 1'b1, -1);
        drain("R8");

        // R7 no buffer open: idle limit reached silently
        buf_open = 1'b0;
        send_frame(8'h42, 1'b0, 1'b1, -1);
        send_frame(8'hFF, 1'b0, 1'b1, -1);
        send_frame(8'hFF, 1'b0, 1'b1, -1);
        send_frame(8'hFF, 1'b0, 1'b1, -1);
        drain("R7");
        chk_irqs("R7");
        buf_open = 1'b1;

        // R9 R10 breaks: measured, saturated, without buffer
        send_break(12);
        chk(brk_count == BCW'(m_brkcnt), "R9", "brk_count", int'(brk_count), m_brkcnt);
        chk(brk_len == LW'(m_brklen), "R9", "brk_len 12", int'(brk_len), m_brklen);
        drain("R10");
        send_break(20);
        chk(brk_len == LW'(m_brklen), "R9", "brk_len saturated", int'(brk_len), m_brklen);
        drain("R10");
        buf_open = 1'b0;
        send_break(11);
        chk(brk_count == BCW'(m_brkcnt), "R9", "brk_count third", int'(brk_count), m_brkcnt);
        chk(brk_len == LW'(m_brklen), "R9", "brk_len 11", int'(brk_len), m_brklen);
        drain("R10");
        buf_open = 1'b1;
        chk_irqs("R11");

        // R11 enables low: records still pushed, no pulses
        rx_irq_en  = 1'b0;
        brk_irq_en = 1'b0;
        send_frame(8'h6E, 1'b0, 1'b0, -1);
        send_break(13);
        drain("R11");
        chk_irqs("R11");
        chk(brk_count == BCW'(m_brkcnt), "R9", "brk_count with irq off", int'(brk_count), m_brkcnt);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule